// File: doc/BRIEF.md
# S/T Interface Multiframe Controller

This block sequences the network-side multiframe of a basic-rate S/T interface. An external framer pulses a strobe at the start of every line frame. The block keeps a 20-frame position count. For each frame it produces the three overhead bits that the framer inserts toward the terminal: the FA-position bit, the M bit and the S bit. In the other direction it captures the four Q bits that the terminal returns in the FA position, and it flags any change in them.

Software loads the four outgoing S bits into a transmit register. It reads the captured Q bits from a receive register. A sticky change flag, cleared by a pulse, signals that the Q channel has changed. An enable input switches multiframe generation off. While it is off, the overhead bits are held at zero and Q capture stops. The frame count keeps running, so alignment is preserved when generation is switched back on.

Top module: `st_mf_ctrl`

## Requirements
- R1: Each frame strobe starts the frame whose number is held in a position count. The count runs 1 to 20 and then returns to 1. The first strobe after reset starts frame 1.
- R2: While enabled, fa_tx_o is 1 in frames 1, 6, 11 and 16 and 0 in all other frames.
- R3: While enabled, m_tx_o is 1 in frame 1 only.
- R4: While enabled, s_tx_o carries s_tx_reg_i bit 0, 1, 2 and 3 in frames 1, 6, 11 and 16 respectively, and is 0 in all other frames.
- R5: All four S bits are taken from s_tx_reg_i on the strobe that starts frame 1. A change to s_tx_reg_i after that strobe only takes effect in the next multiframe.
- R6: While enabled, the value of fa_rx_i on the strobe that starts frame 1, 6, 11 or 16 is stored in q_rx_o bit 0, 1, 2 or 3 respectively. It is visible one clock later. All other Q bits keep their values.
- R7: q_chg_irq_o goes to 1 one clock after a capture that changes a stored Q bit. It stays at 1 until a q_clr_i pulse clears it. If a change and a clear occur in the same cycle, the flag stays at 1.
- R8: While mf_en_i is 0:
  - fa_tx_o, m_tx_o and s_tx_o are 0 from the next clock on.
  - q_rx_o does not change.
  - q_chg_irq_o is not set.
  - The position count still advances on every strobe.
- R9: While rst_ni is low, all outputs are 0. After reset is released, the next strobe starts frame 1.
- R10: The overhead bits for a frame appear one clock after its strobe. They are held until the next strobe, or until generation is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_strobe_i | input | 1 | One-cycle pulse that starts a frame |
| mf_en_i | input | 1 | Multiframe generation enable |
| fa_rx_i | input | 1 | Received FA-position bit, valid with the strobe |
| s_tx_reg_i | input | NUM_SLOTS | Transmit S register; bit 0 is S1 |
| q_clr_i | input | 1 | Clears the Q change flag |
| fa_tx_o | output | 1 | FA-position bit for the current frame |
| m_tx_o | output | 1 | M bit for the current frame |
| s_tx_o | output | 1 | S bit for the current frame |
| q_rx_o | output | NUM_SLOTS | Received Q register; bit 0 is Q1 |
| q_chg_irq_o | output | 1 | Sticky Q change flag |

## Verification
The position count is not visible at the ports, so a wrong count shows up in the overhead bits. One clock after a strobe, m_tx_o rises in the wrong frame or fa_tx_o drops out of its five-frame spacing. Any slip therefore becomes visible within one multiframe, at most 20 strobes. A fault in the S holding register or in Q capture shows at the first S slot, or the first Q slot, that follows it. A wrong change-flag state shows one clock after the affected capture or clear.

// File: rtl/st_mf_pkg.sv
package st_mf_pkg;
  localparam int unsigned MF_LEN_DEF      = 20;
  localparam int unsigned SLOT_STRIDE_DEF = 5;
  localparam int unsigned NUM_SLOTS_DEF   = 4;

  typedef struct packed {
    logic fa;
    logic m;
    logic s;
  } tx_bits_t;
endpackage

// File: rtl/st_mf_frame_cnt.sv
module st_mf_frame_cnt #(
  parameter int unsigned MF_LEN = 20,
  localparam int unsigned CW = $clog2(MF_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strobe_i,
  output logic [CW-1:0] frame_o
);
  localparam logic [CW-1:0] FIRST = CW'(1);
  localparam logic [CW-1:0] LAST  = CW'(MF_LEN);

  logic [CW-1:0] next_q;

  // next_q holds the number of the frame the next strobe starts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       next_q <= FIRST;
    else if (strobe_i) next_q <= (next_q == LAST) ? FIRST : next_q + CW'(1);
  end

  assign frame_o = next_q;

  a_r1_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (next_q >= FIRST) && (next_q <= LAST));
  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && next_q == LAST) |=> (next_q == FIRST));
  a_r1_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(next_q));
endmodule

// File: rtl/st_mf_slot_dec.sv
module st_mf_slot_dec #(
  parameter int unsigned MF_LEN      = 20,
  parameter int unsigned SLOT_STRIDE = 5,
  parameter int unsigned NUM_SLOTS   = 4,
  localparam int unsigned CW = $clog2(MF_LEN + 1)
) (
  input  logic [CW-1:0]        frame_i,
  output logic [NUM_SLOTS-1:0] slot_hit_o,
  output logic                 first_o
);
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam logic [CW-1:0] POS = CW'(1 + k * SLOT_STRIDE);
    assign slot_hit_o[k] = (frame_i == POS);
  end

  assign first_o = (frame_i == CW'(1));

  always_comb begin
    a_r2_slots_exclusive: assert ($onehot0(slot_hit_o));
  end
endmodule

// File: rtl/st_mf_tx_gen.sv
module st_mf_tx_gen
  import st_mf_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 strobe_i,
  input  logic                 en_i,
  input  logic [NUM_SLOTS-1:0] slot_hit_i,
  input  logic                 first_i,
  input  logic [NUM_SLOTS-1:0] s_reg_i,
  output tx_bits_t             bits_o
);
  logic [NUM_SLOTS-1:0] s_hold_q;
  logic [NUM_SLOTS-1:0] s_pick;
  tx_bits_t             bits_q, bits_d;

  // slot 0 uses the live register: that is the sampling instant
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_pick
    if (k == 0) begin : g_live
      assign s_pick[k] = slot_hit_i[k] & s_reg_i[k];
    end else begin : g_held
      assign s_pick[k] = slot_hit_i[k] & s_hold_q[k];
    end
  end

  always_comb begin
    bits_d = bits_q;
    if (!en_i) begin
      bits_d = '0;
    end else if (strobe_i) begin
      bits_d.fa = |slot_hit_i;
      bits_d.m  = first_i;
      bits_d.s  = |s_pick;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q   <= '0;
      s_hold_q <= '0;
    end else begin
      bits_q <= bits_d;
      if (strobe_i && first_i) s_hold_q <= s_reg_i;
    end
  end

  assign bits_o = bits_q;

  a_r8_off_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (bits_o == '0));
  a_r3_m_with_fa: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bits_o.m |-> bits_o.fa);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && en_i) |=> $stable(bits_o));
  a_r5_snapshot_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strobe_i && first_i) |=> $stable(s_hold_q));
endmodule

// File: rtl/st_mf_q_cap.sv
module st_mf_q_cap #(
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 strobe_i,
  input  logic                 en_i,
  input  logic [NUM_SLOTS-1:0] slot_hit_i,
  input  logic                 fa_rx_i,
  input  logic                 clr_i,
  output logic [NUM_SLOTS-1:0] q_o,
  output logic                 irq_o
);
  logic [NUM_SLOTS-1:0] q_q, cap, q_d;
  logic                 irq_q, chg;

  assign cap = (strobe_i && en_i) ? slot_hit_i : '0;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_q
    assign q_d[k] = cap[k] ? fa_rx_i : q_q[k];
  end

  assign chg = |(q_d ^ q_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= '0;
      irq_q <= 1'b0;
    end else begin
      q_q <= q_d;
      // a new change wins over a clear in the same cycle
      if (chg)        irq_q <= 1'b1;
      else if (clr_i) irq_q <= 1'b0;
    end
  end

  assign q_o   = q_q;
  assign irq_o = irq_q;

  a_r6_q_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strobe_i && en_i) |=> $stable(q_o));
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> irq_o);
  a_r7_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (q_o != $past(q_o)));
  a_r8_no_irq_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !irq_o) |=> !irq_o);
endmodule

// File: rtl/st_mf_ctrl.sv
module st_mf_ctrl
  import st_mf_pkg::*;
#(
  parameter int unsigned MF_LEN      = MF_LEN_DEF,
  parameter int unsigned SLOT_STRIDE = SLOT_STRIDE_DEF,
  parameter int unsigned NUM_SLOTS   = NUM_SLOTS_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frame_strobe_i,
  input  logic                 mf_en_i,
  input  logic                 fa_rx_i,
  input  logic [NUM_SLOTS-1:0] s_tx_reg_i,
  input  logic                 q_clr_i,
  output logic                 fa_tx_o,
  output logic                 m_tx_o,
  output logic                 s_tx_o,
  output logic [NUM_SLOTS-1:0] q_rx_o,
  output logic                 q_chg_irq_o
);
  localparam int unsigned CW = $clog2(MF_LEN + 1);

  logic [CW-1:0]        frame;
  logic [NUM_SLOTS-1:0] slot_hit;
  logic                 first;
  tx_bits_t             tx_bits;

  st_mf_frame_cnt #(.MF_LEN(MF_LEN)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (frame_strobe_i),
    .frame_o  (frame)
  );

  st_mf_slot_dec #(
    .MF_LEN      (MF_LEN),
    .SLOT_STRIDE (SLOT_STRIDE),
    .NUM_SLOTS   (NUM_SLOTS)
  ) u_dec (
    .frame_i    (frame),
    .slot_hit_o (slot_hit),
    .first_o    (first)
  );

  st_mf_tx_gen #(.NUM_SLOTS(NUM_SLOTS)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (frame_strobe_i),
    .en_i       (mf_en_i),
    .slot_hit_i (slot_hit),
    .first_i    (first),
    .s_reg_i    (s_tx_reg_i),
    .bits_o     (tx_bits)
  );

  st_mf_q_cap #(.NUM_SLOTS(NUM_SLOTS)) u_q (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (frame_strobe_i),
    .en_i       (mf_en_i),
    .slot_hit_i (slot_hit),
    .fa_rx_i    (fa_rx_i),
    .clr_i      (q_clr_i),
    .q_o        (q_rx_o),
    .irq_o      (q_chg_irq_o)
  );

  assign fa_tx_o = tx_bits.fa;
  assign m_tx_o  = tx_bits.m;
  assign s_tx_o  = tx_bits.s;

  a_r3_m_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_strobe_i && mf_en_i && !first) |=> !m_tx_o);
  a_r2_fa_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_strobe_i && mf_en_i && first) |=> fa_tx_o);
endmodule

// File: tb/tb_st_mf_ctrl.sv
module tb_st_mf_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MF = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0, en = 1'b0, fa_rx = 1'b0, clr = 1'b0;
  logic [3:0] s_reg = '0;
  logic       fa_tx, m_tx, s_tx, irq;
  logic [3:0] q_rx;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  int         nf = 1;
  logic [3:0] m_shold = '0, m_q = '0;
  logic       m_fa = 0, m_m = 0, m_s = 0, m_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  st_mf_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_strobe_i(strobe), .mf_en_i(en),
    .fa_rx_i(fa_rx), .s_tx_reg_i(s_reg), .q_clr_i(clr),
    .fa_tx_o(fa_tx), .m_tx_o(m_tx), .s_tx_o(s_tx), .q_rx_o(q_rx),
    .q_chg_irq_o(irq)
  );

  function automatic logic exp_fa(int f);
    return (f == 1) || (f == 6) || (f == 11) || (f == 16);
  endfunction
  function automatic logic exp_m(int f);
    return f == 1;
  endfunction
  function automatic logic exp_s(int f, logic [3:0] live, logic [3:0] held);
    if (f == 1) return live[0];
    if (exp_fa(f)) return held[(f-1)/5];
    return 1'b0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    nf = 1; m_shold = '0; m_q = '0;
    m_fa = 0; m_m = 0; m_s = 0; m_irq = 0;
  endtask

  // one clock: inputs set now (after negedge), compare at the next negedge
  task automatic cyc(bit stb, bit e, bit fr, logic [3:0] s, bit c);
    int st;
    bit chg;
    strobe = stb; en = e; fa_rx = fr; s_reg = s; clr = c;
    st = nf;
    chg = 0;
    if (!e) begin
      m_fa = 0; m_m = 0; m_s = 0;
    end else if (stb) begin
      m_fa = exp_fa(st); m_m = exp_m(st); m_s = exp_s(st, s, m_shold);
    end
    if (stb && e && exp_fa(st)) begin
      if (m_q[(st-1)/5] != fr) chg = 1;
      m_q[(st-1)/5] = fr;
    end
    if (stb && st == 1) m_shold = s;
    if (stb) nf = (nf == MF) ? 1 : nf + 1;
    if (chg) m_irq = 1; else if (c) m_irq = 0;
    @(posedge clk);
    @(negedge clk);
    strobe = 0; clr = 0;
    chk(e ? "R2" : "R8", "fa_tx", fa_tx, m_fa);
    chk(e ? "R3" : "R8", "m_tx", m_tx, m_m);
    chk(e ? "R4" : "R8", "s_tx", s_tx, m_s);
    chk(e ? "R6" : "R8", "q_rx", q_rx, m_q);
    chk(e ? "R7" : "R8", "irq", irq, m_irq);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5717));
    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9", "fa_tx reset", fa_tx, 0);
    chk("R9", "m_tx reset", m_tx, 0);
    chk("R9", "s_tx reset", s_tx, 0);
    chk("R9", "q_rx reset", q_rx, 0);
    chk("R9", "irq reset", irq, 0);
    rst_n = 1;
    model_reset();
    @(negedge clk);

    // R1: walk a full multiframe plus one, first strobe is frame 1
    for (int i = 0; i < MF; i++) begin
      cyc(1, 1, 0, 4'b1011, 0);
      if (i == 0) chk("R1", "m at first strobe", m_tx, 1);
      cyc(0, 1, 0, 4'b1011, 0);
      chk("R10", "hold between strobes", {fa_tx, m_tx, s_tx}, {m_fa, m_m, m_s});
    end
    cyc(1, 1, 0, 4'b1011, 0);
    chk("R1", "m after wrap", m_tx, 1);

    // R5: write mid-multiframe, frame 6 must still use old snapshot (bit1=1)
    for (int f = 2; f <= 5; f++) cyc(1, 1, 0, 4'b1011, 0);
    s_reg = 4'b0000;
    cyc(1, 1, 0, 4'b0000, 0);
    chk("R5", "S2 from snapshot", s_tx, 1);
    for (int f = 7; f <= MF; f++) cyc(1, 1, 0, 4'b0000, 0);
    cyc(1, 1, 0, 4'b0000, 0);
    chk("R5", "S1 new multiframe", s_tx, 0);

    // R7: change and clear together, flag stays set; then clear
    for (int f = 2; f <= 5; f++) cyc(1, 1, 0, 4'b0000, 0);
    cyc(1, 1, 1, 4'b0000, 1);
    chk("R7", "change beats clear", irq, 1);
    cyc(0, 1, 0, 4'b0000, 1);
    chk("R7", "clear", irq, 0);

    // R8: disabled, Q differs but must not be captured
    for (int f = 7; f <= 10; f++) cyc(1, 0, 0, 4'b1111, 0);
    cyc(1, 0, 1, 4'b1111, 0);
    chk("R8", "q held off", q_rx, m_q);
    chk("R8", "no irq off", irq, 0);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      bit stb, e, fr, c;
      logic [3:0] s;
      stb = ($urandom % 3) == 0;
      e   = ($urandom % 10) != 0;
      fr  = $urandom % 2;
      c   = ($urandom % 8) == 0;
      s   = (($urandom % 30) == 0) ? 4'($urandom) : s_reg;
      cyc(stb, e, fr, s, c);
    end

    // R9: reset mid-run, next strobe starts frame 1
    rst_n = 0;
    #1;
    chk("R9", "async reset outputs", {fa_tx, m_tx, s_tx, irq}, 0);
    chk("R9", "async reset q", q_rx, 0);
    @(negedge clk);
    rst_n = 1;
    model_reset();
    @(negedge clk);
    cyc(1, 1, 1, 4'b0001, 0);
    chk("R9", "frame 1 after reset", {fa_tx, m_tx, s_tx}, 3'b111);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule